// File: doc/BRIEF.md
# Two-Phase Polyphase FIR Lane Bank

This block is a streaming polyphase filter datapath. Each input word is a 32-bit stream beat. Its low byte is the 8-bit unsigned sample, and the upper bits carry nothing the filter uses. Every lane in the bank multiplies the sample by its own four 12-bit coefficients. Each 20-bit product is cut down to an 8-bit term, and the terms are folded into one of two transposed delay chains. An even/odd phase flag picks the chain. The even chain consumes the terms in coefficient order and the odd chain consumes them reversed, so the two chains interleave as the two polyphase branches.

Each sample that is accepted yields one filtered byte per lane. The bank shares one valid/ready input stream and one valid/ready output stream. The output carries one 32-bit word per lane. The pipeline takes one sample per clock while the output is ready, and back-pressure freezes every stage at once. A beat flagged as end of stream ends processing. Coefficients are written through a small configuration port before the stream starts.

Top module: `ppf_bank`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, the phase is even, and every even-chain and odd-chain register is 0.
- R2: The sample is in_data[7:0]. Bits [31:8] of an input word have no effect on any result.
- R3: For a coefficient Ck (12-bit unsigned), term tk is bits [19:12] of the 20-bit product sample × Ck.
- R4: In the even phase, result = e1 + t1. Then e1 takes e2 + t2, e2 takes e3 + t3, and e3 takes t4. The odd chain is left unchanged.
- R5: In the odd phase, result = o1 + t4. Then o1 takes o2 + t3, o2 takes o3 + t2, and o3 takes t1. The even chain is left unchanged.
- R6: The phase flips after every processed sample, so the samples alternate even, odd, even, and so on, starting with even.
- R7: All sums are 8-bit unsigned and wrap modulo 256.
- R8: The word of lane i is out_data[32i+31:32i]. The result byte is in bits [7:0] and bits [31:8] are 0.
- R9: A sample accepted at clock edge k has its result on out_data, with out_valid high, after edge k+1 when out_ready is high. Back-to-back samples are accepted on every clock.
- R10: While out_valid is 1 and out_ready is 0, out_data and out_valid hold, in_ready is 0, and no input beat is accepted.
- R11: A beat accepted with in_eos = 1 produces no result and leaves the chains and phase unchanged. From then on in_ready stays 0 until reset.
- R12: When cfg_we = 1, cfg_coef is written into coefficient cfg_tap of lane cfg_lane, where tap codes 0, 1, 2 and 3 select C1, C2, C3 and C4. Reset clears all coefficients to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_lane | input | LANE_IW (2) | Lane selected for the coefficient write |
| cfg_tap | input | 2 | Coefficient index, 0..3 meaning C1..C4 |
| cfg_coef | input | COEF_W (12) | Coefficient value |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_data | input | WORD_W (32) | Input word; sample in bits [7:0] |
| in_eos | input | 1 | Marks the beat as end of stream |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can take the output word |
| out_data | output | LANES*WORD_W (128) | One result word per lane |

## Verification
The datapath has two register stages. A sample accepted at edge k shows its result after edge k+1. The bench therefore drives a beat at a falling edge and compares the matching output two falling edges later, while the next beats stream in behind it. Under back-pressure the result that is already held must stay on the port on every falling edge of the stall. The next result must follow one edge after out_ready rises. End of stream is checked on the falling edge right after the marker beat. From there, in_ready is low and out_valid stays low for several cycles. After reset, the first result is expected two edges after the first beat. It is compared with a value worked out by hand for cleared chains.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

   // Number of coefficients per lane; the chain recurrences assume four.
   localparam int NUM_TAPS = 4;

   typedef enum logic {
      PH_EVEN = 1'b0,
      PH_ODD  = 1'b1
   } phase_e;

endpackage

// File: rtl/ppf_term.sv
// One coefficient product, sliced down to a sample-wide term.
module ppf_term #(
   parameter int SAMPLE_W  = 8,
   parameter int COEF_W    = 12,
   parameter int SLICE_LSB = 12
) (
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic [COEF_W-1:0]   coef_i,
   output logic [SAMPLE_W-1:0] term_o
);

   localparam int PROD_W = SAMPLE_W + COEF_W;

   generate
      if (SLICE_LSB + SAMPLE_W > PROD_W) begin : g_bad_slice
         $error("ppf_term: slice runs past the product width");
      end
   endgenerate

   logic [PROD_W-1:0] prod;

   assign prod   = PROD_W'(sample_i) * PROD_W'(coef_i);
   assign term_o = SAMPLE_W'(prod >> SLICE_LSB);

endmodule

// File: rtl/ppf_lane.sv
// One filter lane: NUM_TAPS terms feeding an even and an odd transposed chain.
module ppf_lane
   import ppf_pkg::*;
#(
   parameter int SAMPLE_W  = 8,
   parameter int COEF_W    = 12,
   parameter int SLICE_LSB = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       upd_i,
   input  phase_e                     phase_i,
   input  logic [SAMPLE_W-1:0]        sample_i,
   input  logic [NUM_TAPS*COEF_W-1:0] coefs_i,
   output logic [SAMPLE_W-1:0]        result_o
);

   localparam int DEPTH = NUM_TAPS - 1;

   logic [NUM_TAPS-1:0][SAMPLE_W-1:0] term;
   logic [DEPTH-1:0][SAMPLE_W-1:0]    even_q;
   logic [DEPTH-1:0][SAMPLE_W-1:0]    odd_q;

   generate
      for (genvar k = 0; k < NUM_TAPS; k++) begin : g_term
         ppf_term #(
            .SAMPLE_W (SAMPLE_W),
            .COEF_W   (COEF_W),
            .SLICE_LSB(SLICE_LSB)
         ) u_term (
            .sample_i(sample_i),
            .coef_i  (coefs_i[k*COEF_W +: COEF_W]),
            .term_o  (term[k])
         );
      end
   endgenerate

   // Even branch walks the terms forwards, odd branch walks them backwards.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         even_q   <= '0;
         odd_q    <= '0;
         result_o <= '0;
      end else if (upd_i) begin
         if (phase_i == PH_EVEN) begin
            result_o <= even_q[0] + term[0];
            for (int j = 0; j < DEPTH-1; j++) begin
               even_q[j] <= even_q[j+1] + term[j+1];
            end
            even_q[DEPTH-1] <= term[NUM_TAPS-1];
         end else begin
            result_o <= odd_q[0] + term[NUM_TAPS-1];
            for (int j = 0; j < DEPTH-1; j++) begin
               odd_q[j] <= odd_q[j+1] + term[NUM_TAPS-2-j];
            end
            odd_q[DEPTH-1] <= term[0];
         end
      end
   end

   AST_EVEN_KEPT_ON_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && phase_i == PH_ODD) |=> $stable(even_q));   // R5
   AST_ODD_KEPT_ON_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && phase_i == PH_EVEN) |=> $stable(odd_q));   // R4
   AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(result_o));                        // R10

endmodule

// File: rtl/ppf_bank.sv
// Bank of polyphase filter lanes sharing one input and one output stream.
module ppf_bank
   import ppf_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int WORD_W    = 32,
   parameter int SAMPLE_W  = 8,
   parameter int COEF_W    = 12,
   parameter int SLICE_LSB = 12,
   localparam int LANE_IW  = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int TAP_IW   = $clog2(NUM_TAPS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [LANE_IW-1:0]      cfg_lane,
   input  logic [TAP_IW-1:0]       cfg_tap,
   input  logic [COEF_W-1:0]       cfg_coef,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [WORD_W-1:0]       in_data,
   input  logic                    in_eos,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [LANES*WORD_W-1:0] out_data
);

   localparam int PAD_W = WORD_W - SAMPLE_W;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("ppf_bank: LANES must be at least 1");
      end
      if (WORD_W <= SAMPLE_W) begin : g_bad_word
         $error("ppf_bank: WORD_W must exceed SAMPLE_W");
      end
   endgenerate

   logic                advance;
   logic                fire;
   logic                upd;
   logic                halted_q;
   logic                s1_valid;
   logic [SAMPLE_W-1:0] s1_sample;
   phase_e              phase_q;

   // Any free output slot lets every stage move together.
   assign advance  = !out_valid || out_ready;
   assign in_ready = advance && !halted_q;
   assign fire     = in_valid && in_ready;
   assign upd      = advance && s1_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_sample <= '0;
         out_valid <= 1'b0;
         halted_q  <= 1'b0;
         phase_q   <= PH_EVEN;
      end else begin
         if (fire && in_eos) begin
            halted_q <= 1'b1;
         end
         if (advance) begin
            s1_valid  <= fire && !in_eos;
            s1_sample <= in_data[SAMPLE_W-1:0];
            out_valid <= s1_valid;
         end
         if (upd) begin
            phase_q <= (phase_q == PH_EVEN) ? PH_ODD : PH_EVEN;
         end
      end
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [NUM_TAPS*COEF_W-1:0] coef_q;
         logic [SAMPLE_W-1:0]        res;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               coef_q <= '0;
            end else if (cfg_we && cfg_lane == LANE_IW'(l)) begin
               coef_q[cfg_tap*COEF_W +: COEF_W] <= cfg_coef;
            end
         end

         ppf_lane #(
            .SAMPLE_W (SAMPLE_W),
            .COEF_W   (COEF_W),
            .SLICE_LSB(SLICE_LSB)
         ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_i   (upd),
            .phase_i (phase_q),
            .sample_i(s1_sample),
            .coefs_i (coef_q),
            .result_o(res)
         );

         assign out_data[l*WORD_W +: WORD_W] = {{PAD_W{1'b0}}, res};
      end
   endgenerate

   AST_INPUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> !$isunknown(in_data));                              // R2
   AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_eos) |=> ##1 out_valid);            // R9
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10
   AST_EOS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_eos) |=> !in_ready);                 // R11

endmodule

// File: tb/ppf_bank_tb_top.sv
module ppf_bank_tb_top;

   localparam int NL = 4;
   localparam int NV = 10;

   // {input word, lane0 expected, lane1 expected}; lane0 C = 0x100,0x200,0x400,0x800,
   // lane1 C = 0xFFF on every tap. Upper input bytes are junk (R2).
   localparam logic [47:0] VEC [NV] = '{
      {32'hABCD_00F0, 8'd15,  8'd239},
      {32'h1234_5680, 8'd64,  8'd127},
      {32'hFFFF_FFFF, 8'd45,  8'd237},
      {32'h0000_0040, 8'd64,  8'd190},
      {32'h5A5A_A5FF, 8'd106, 8'd235},
      {32'hFFFF_FF00, 8'd32,  8'd190},
      {32'h0F0F_0FFF, 8'd229, 8'd233},
      {32'h8000_00FF, 8'd143, 8'd188},
      {32'h7777_77FF, 8'd236, 8'd248},
      {32'h0101_01FF, 8'd194, 8'd59}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_we = 1'b0;
   logic [1:0]     cfg_lane = '0;
   logic [1:0]     cfg_tap = '0;
   logic [11:0]    cfg_coef = '0;
   logic           in_valid = 1'b0;
   logic           in_ready;
   logic [31:0]    in_data = '0;
   logic           in_eos = 1'b0;
   logic           out_valid;
   logic           out_ready = 1'b1;
   logic [NL*32-1:0] out_data;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   logic [11:0] mc  [NL][4];
   logic [7:0]  mev [NL][3];
   logic [7:0]  mov [NL][3];
   bit          mph;
   logic [NL*8-1:0] expq [NV];

   always #2 clk = ~clk;

   ppf_bank dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lane(cfg_lane),
      .cfg_tap(cfg_tap), .cfg_coef(cfg_coef), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .in_eos(in_eos),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_lanes(input string req, input logic [NL*8-1:0] exp);
      for (int l = 0; l < NL; l++) chk(req, out_data[l*32 +: 32], {24'h0, exp[l*8 +: 8]});
   endtask

   function automatic logic [7:0] mterm(input int l, input int k, input logic [7:0] s);
      logic [19:0] p;
      p = s * mc[l][k];
      return p[19:12];   // R3
   endfunction

   task automatic model_clear(input bit coefs_too);
      for (int l = 0; l < NL; l++) begin
         for (int j = 0; j < 3; j++) begin mev[l][j] = '0; mov[l][j] = '0; end
         if (coefs_too) for (int k = 0; k < 4; k++) mc[l][k] = '0;
      end
      mph = 1'b0;
   endtask

   task automatic model_step(input logic [7:0] s, output logic [NL*8-1:0] y);
      logic [7:0] t [4];
      for (int l = 0; l < NL; l++) begin
         for (int k = 0; k < 4; k++) t[k] = mterm(l, k, s);
         if (!mph) begin
            y[l*8 +: 8] = mev[l][0] + t[0];
            mev[l][0] = mev[l][1] + t[1];
            mev[l][1] = mev[l][2] + t[2];
            mev[l][2] = t[3];
         end else begin
            y[l*8 +: 8] = mov[l][0] + t[3];
            mov[l][0] = mov[l][1] + t[2];
            mov[l][1] = mov[l][2] + t[1];
            mov[l][2] = t[0];
         end
      end
      mph = !mph;
   endtask

   task automatic load(input int l, input int k, input logic [11:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_lane = 2'(l); cfg_tap = 2'(k); cfg_coef = v;
      mc[l][k] = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load_all();
      load(0, 0, 12'h100); load(0, 1, 12'h200); load(0, 2, 12'h400); load(0, 3, 12'h800);
      for (int k = 0; k < 4; k++) load(1, k, 12'hFFF);
      load(2, 0, 12'h123); load(2, 1, 12'h456); load(2, 2, 12'h789); load(2, 3, 12'hABC);
      load(3, 0, 12'hFFF); load(3, 1, 12'h001); load(3, 2, 12'h800); load(3, 3, 12'h0F0);
   endtask

   initial begin
      logic [NL*8-1:0] ea, eb, ed, eh, ef;
      model_clear(1'b1);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
      chk("R1 in_ready in reset", 32'(in_ready), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
      load_all();   // R12

      // Table walk, back-to-back beats (R9 throughput, results two edges later)
      for (int i = 0; i < NV + 2; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            chk("R9 out_valid", 32'(out_valid), 32'd1);
            chk((i % 2 == 0) ? "R2 R4 R8 lane0 even" : "R2 R5 R8 lane0 odd",
                out_data[31:0], {24'h0, VEC[i-2][15:8]});
            chk("R7 lane1 wrap", out_data[63:32], {24'h0, VEC[i-2][7:0]});
            chk("R6 R3 lane2", out_data[95:64], {24'h0, expq[i-2][23:16]});
            chk("R12 lane3", out_data[127:96], {24'h0, expq[i-2][31:24]});
         end
         if (i < NV) begin
            chk("R9 in_ready streaming", 32'(in_ready), 32'd1);
            in_valid = 1'b1;
            in_data  = VEC[i][47:16];
            model_step(VEC[i][23:16], expq[i]);
         end else begin
            in_valid = 1'b0;
         end
      end
      @(negedge clk);
      chk("R9 drained", 32'(out_valid), 32'd0);

      // R10: back-pressure
      out_ready = 1'b0;
      in_valid = 1'b1; in_data = 32'hDEAD_BE37; model_step(8'h37, ea);
      @(negedge clk);
      chk("R10 in_ready before stall", 32'(in_ready), 32'd1);
      in_data = 32'h0000_009C; model_step(8'h9C, eb);
      @(negedge clk);
      in_data = 32'h0000_00E1;   // must not be taken
      for (int c = 0; c < 4; c++) begin
         chk("R10 in_ready stalled", 32'(in_ready), 32'd0);
         chk("R10 out_valid held", 32'(out_valid), 32'd1);
         chk_lanes("R10 data held", ea);
         @(negedge clk);
      end
      out_ready = 1'b1; in_valid = 1'b0;
      @(negedge clk);
      chk("R10 next result", 32'(out_valid), 32'd1);
      chk_lanes("R10 second result", eb);
      @(negedge clk);
      chk("R10 empty after stall", 32'(out_valid), 32'd0);
      in_valid = 1'b1; in_data = 32'h0000_005A; model_step(8'h5A, ed);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk_lanes("R10 stalled beat ignored", ed);

      // R11: end of stream
      in_valid = 1'b1; in_eos = 1'b1; in_data = 32'h0000_00FF;
      @(negedge clk);
      in_eos = 1'b0; in_data = 32'h0000_0011;
      for (int c = 0; c < 5; c++) begin
         chk("R11 in_ready after eos", 32'(in_ready), 32'd0);
         chk("R11 no output after eos", 32'(out_valid), 32'd0);
         @(negedge clk);
      end
      in_valid = 1'b0;

      // R1 / R12: reset clears chains, phase and coefficients
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_clear(1'b1);
      chk("R1 in_ready after reset", 32'(in_ready), 32'd1);
      chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
      in_valid = 1'b1; in_data = 32'h0000_00FF; model_step(8'hFF, eh);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk_lanes("R12 zero coefficients after reset", 32'h0);
      load_all();
      @(negedge clk);
      in_valid = 1'b1; in_data = 32'h0000_00C8; model_step(8'hC8, ef);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R1 R5 lane0 odd from cleared chain", out_data[31:0], 32'd100);
      chk_lanes("R1 all lanes after reset", ef);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R9 watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule